// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps account of cache misses sent from the first-level caches toward the next memory level. Misses from the load pipe go into a pool of data entries. Misses from the fetch unit go into a separate, smaller pool of instruction entries. A load that misses on a 32-byte block that already has a request in flight joins that entry and sends no second request. Each data entry can hold a small list of waiting loads. For each one it keeps the destination register tag and the byte offset inside the block.

Only newly allocated entries produce a request. Requests leave one per cycle in allocation order, and each carries a global entry index. The next level later returns a fill tagged with that index. A data fill is followed by one completion per waiting load on successive cycles, and the entry is released after the last one. An instruction fill completes and releases its entry at once. When a load can neither merge nor allocate, the block raises a replay indication in the same cycle so that the load and everything younger can be re-executed.

Top module: `miss_tracker`

## Requirements
- R1: After reset, no output valid, replay, stall or completion is asserted, and every entry is free.
- R2: There are six data entries and four instruction entries. A new miss takes the lowest-numbered free entry of its pool.
- R3: A load whose block address (address bits 31..5) equals that of a data entry still waiting for its fill is added to that entry. It produces no new request.
- R4: A load that matches no waiting entry, arriving when all six data entries are in use, asserts ld_replay in that same cycle and leaves all state unchanged.
- R5: A load that matches a waiting entry already holding four loads asserts ld_replay in that same cycle and leaves all state unchanged.
- R6: Each allocation queues one request, and one request is presented per cycle, starting the cycle after allocation, in allocation order. A data allocation is queued ahead of an instruction allocation made in the same cycle. Indices 0 to 5 name data entries and 6 to 9 name instruction entries.
- R7: A fill for a waiting data entry makes it ready. From the next cycle, the lowest-numbered ready entry emits its loads one per cycle in merge order, with tag and offset. The entry becomes free after its last completion.
- R8: A fill for a busy instruction entry asserts if_done_valid with that entry's block address in the same cycle, and the entry is free from the next cycle.
- R9: A fetch miss when all four instruction entries are busy asserts if_stall in that cycle and is dropped.
- R10: A fill whose index names a data entry that is not waiting, an instruction entry that is not busy, or no entry at all (10 to 15) produces no completion and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_miss_valid | input | 1 | Load miss present this cycle |
| ld_miss_addr | input | 32 | Byte address of the load miss |
| ld_miss_dst | input | 6 | Destination register tag of the load |
| ld_replay | output | 1 | Load could not be accepted; replay it |
| if_miss_valid | input | 1 | Fetch miss present this cycle |
| if_miss_addr | input | 32 | Byte address of the fetch miss |
| if_stall | output | 1 | Fetch miss dropped, instruction pool full |
| req_valid | output | 1 | Request to next level valid |
| req_idx | output | 4 | Global entry index of the request |
| req_blk | output | 27 | Block address of the request |
| fill_valid | input | 1 | Fill returned from next level |
| fill_idx | input | 4 | Global entry index of the fill |
| ld_done_valid | output | 1 | Load completion valid |
| ld_done_dst | output | 6 | Destination tag of completed load |
| ld_done_off | output | 5 | Byte offset of completed load |
| if_done_valid | output | 1 | Instruction fill completion |
| if_done_blk | output | 27 | Block address of completed fetch |

## Verification
The assertions assume that the next level never returns a fill for a data entry before that entry's request has appeared on the request port. No cycle-level protocol beyond that is assumed, and each miss input is taken as a single-cycle event. The stimulus obeys the rule by aiming fills only at entries whose request it has already seen. Fills meant to be ignored go only to idle data entries, to data entries that are draining, to idle instruction entries, or to indices past the last entry. Load addresses come from a small set of blocks, so merging, full merge lists and a full pool all occur often.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    E_IDLE   = 2'd0,
    E_WAIT   = 2'd1,
    E_FILLED = 2'd2
  } dent_e;

  // lowest set bit of a vector, 0 when empty
  function automatic int first_one(input logic [31:0] v);
    first_one = 0;
    for (int k = 31; k >= 0; k--) begin
      if (v[k]) first_one = k;
    end
  endfunction

endpackage

// File: rtl/mt_req_queue.sv
module mt_req_queue #(
  parameter int DEPTH = 10,
  parameter int IDX_W = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic             push_b,
  input  logic [IDX_W-1:0] idx_b,
  output logic             head_valid,
  output logic [IDX_W-1:0] head_idx
);

  logic [IDX_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p, input int step);
    int t;
    t = int'(p) + step;
    if (t >= DEPTH) t = t - DEPTH;
    return PTR_W'(t);
  endfunction

  assign head_valid = (cnt_q != '0);
  assign head_idx   = mem_q[rd_q];
  assign pop        = head_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_a) mem_q[wr_q] <= idx_a;
      if (push_b) mem_q[wrap(wr_q, push_a ? 1 : 0)] <= idx_b;
      wr_q  <= wrap(wr_q, int'(push_a) + int'(push_b));
      if (pop) rd_q <= wrap(rd_q, 1);
      cnt_q <= cnt_q + CNT_W'(push_a) + CNT_W'(push_b) - CNT_W'(pop);
    end
  end

  AST_QUEUE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt_q) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH); // R6

  AST_HEAD_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !push_a && !push_b) |=> (int'(cnt_q) == int'($past(cnt_q)) - 1)); // R6

endmodule

// File: rtl/mt_data_pool.sv
module mt_data_pool
  import mt_pkg::*;
#(
  parameter int ENTRIES = 6,
  parameter int SLOTS   = 4,
  parameter int BLK_W   = 27,
  parameter int OFF_W   = 5,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ld_valid,
  input  logic [BLK_W-1:0]                ld_blk,
  input  logic [OFF_W-1:0]                ld_off,
  input  logic [TAG_W-1:0]                ld_dst,
  input  logic                            fill_valid,
  input  logic [IDX_W-1:0]                fill_idx,
  output logic                            alloc_fire,
  output logic [IDX_W-1:0]                alloc_idx,
  output logic                            replay,
  output logic [ENTRIES-1:0][BLK_W-1:0]   blk_tab,
  output logic                            done_valid,
  output logic [TAG_W-1:0]                done_dst,
  output logic [OFF_W-1:0]                done_off
);

  dent_e            st_q  [ENTRIES];
  logic [BLK_W-1:0] blk_q [ENTRIES];
  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [SLOT_W-1:0] ptr_q [ENTRIES];
  logic [TAG_W-1:0] dst_q [ENTRIES][SLOTS];
  logic [OFF_W-1:0] off_q [ENTRIES][SLOTS];

  logic [ENTRIES-1:0] free_v, hit_v, ready_v;
  logic [IDX_W-1:0]   hit_idx, drain_idx;
  logic               hit_any, hit_full, merge_fire, fill_hit, drain_last;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      free_v[i]  = (st_q[i] == E_IDLE);
      hit_v[i]   = (st_q[i] == E_WAIT) && (blk_q[i] == ld_blk);
      ready_v[i] = (st_q[i] == E_FILLED);
      blk_tab[i] = blk_q[i];
    end
  end

  assign hit_any    = |hit_v;
  assign hit_idx    = IDX_W'(first_one(32'(hit_v)));
  assign hit_full   = (cnt_q[hit_idx] == CNT_W'(SLOTS));
  assign merge_fire = ld_valid && hit_any && !hit_full;
  assign alloc_fire = ld_valid && !hit_any && (|free_v);
  assign alloc_idx  = IDX_W'(first_one(32'(free_v)));
  assign replay     = ld_valid && !merge_fire && !alloc_fire;

  assign fill_hit   = fill_valid && (st_q[fill_idx] == E_WAIT);

  assign done_valid = |ready_v;
  assign drain_idx  = IDX_W'(first_one(32'(ready_v)));
  assign done_dst   = dst_q[drain_idx][ptr_q[drain_idx]];
  assign done_off   = off_q[drain_idx][ptr_q[drain_idx]];
  assign drain_last = ((CNT_W'(ptr_q[drain_idx]) + CNT_W'(1)) == cnt_q[drain_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        st_q[i]  <= E_IDLE;
        blk_q[i] <= '0;
        cnt_q[i] <= '0;
        ptr_q[i] <= '0;
        for (int s = 0; s < SLOTS; s++) begin
          dst_q[i][s] <= '0;
          off_q[i][s] <= '0;
        end
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_fire && alloc_idx == IDX_W'(i)) begin
          st_q[i]     <= E_WAIT;
          blk_q[i]    <= ld_blk;
          cnt_q[i]    <= CNT_W'(1);
          ptr_q[i]    <= '0;
          dst_q[i][0] <= ld_dst;
          off_q[i][0] <= ld_off;
        end else if (fill_hit && fill_idx == IDX_W'(i)) begin
          st_q[i] <= E_FILLED;
        end else if (done_valid && drain_idx == IDX_W'(i)) begin
          if (drain_last) begin
            st_q[i]  <= E_IDLE;
            cnt_q[i] <= '0;
            ptr_q[i] <= '0;
          end else begin
            ptr_q[i] <= ptr_q[i] + SLOT_W'(1);
          end
        end
        if (merge_fire && hit_idx == IDX_W'(i)) begin
          dst_q[i][SLOT_W'(cnt_q[i])] <= ld_dst;
          off_q[i][SLOT_W'(cnt_q[i])] <= ld_off;
          cnt_q[i] <= cnt_q[i] + CNT_W'(1);
        end
      end
    end
  end

  AST_REPLAY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> ld_valid); // R4

  AST_ONE_LOAD_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $onehot({merge_fire, alloc_fire, replay})); // R5

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_READY_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[g] == E_FILLED) |-> $past(fill_hit && fill_idx == IDX_W'(g))); // R7
    AST_SLOTS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= CNT_W'(SLOTS)); // R5
  end

endmodule

// File: rtl/mt_inst_pool.sv
module mt_inst_pool
  import mt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 27,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          if_valid,
  input  logic [BLK_W-1:0]              if_blk,
  input  logic                          fill_valid,
  input  logic [IDX_W-1:0]              fill_idx,
  output logic                          alloc_fire,
  output logic [IDX_W-1:0]              alloc_idx,
  output logic                          stall,
  output logic [ENTRIES-1:0][BLK_W-1:0] blk_tab,
  output logic                          done_valid,
  output logic [BLK_W-1:0]              done_blk
);

  logic [ENTRIES-1:0] busy_q;
  logic [BLK_W-1:0]   blk_q [ENTRIES];
  logic               fill_hit;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) blk_tab[i] = blk_q[i];
  end

  assign alloc_fire = if_valid && !(&busy_q);
  assign stall      = if_valid && (&busy_q);
  assign alloc_idx  = IDX_W'(first_one(32'(~busy_q)));
  assign fill_hit   = fill_valid && busy_q[fill_idx];
  assign done_valid = fill_hit;
  assign done_blk   = blk_q[fill_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int i = 0; i < ENTRIES; i++) blk_q[i] <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (alloc_fire && alloc_idx == IDX_W'(i)) begin
          busy_q[i] <= 1'b1;
          blk_q[i]  <= if_blk;
        end else if (fill_hit && fill_idx == IDX_W'(i)) begin
          busy_q[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    AST_INST_FREED: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_hit && fill_idx == IDX_W'(g)) |=> !busy_q[g]); // R8
  end

endmodule

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32,
  parameter int DATA_N    = 6,
  parameter int INST_N    = 4,
  parameter int MERGE_N   = 4,
  parameter int TAG_W     = 6,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int BLK_W    = ADDR_W - OFF_W,
  localparam int TOT_N    = DATA_N + INST_N,
  localparam int GIDX_W   = $clog2(TOT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_miss_valid,
  input  logic [ADDR_W-1:0] ld_miss_addr,
  input  logic [TAG_W-1:0]  ld_miss_dst,
  output logic              ld_replay,
  input  logic              if_miss_valid,
  input  logic [ADDR_W-1:0] if_miss_addr,
  output logic              if_stall,
  output logic              req_valid,
  output logic [GIDX_W-1:0] req_idx,
  output logic [BLK_W-1:0]  req_blk,
  input  logic              fill_valid,
  input  logic [GIDX_W-1:0] fill_idx,
  output logic              ld_done_valid,
  output logic [TAG_W-1:0]  ld_done_dst,
  output logic [OFF_W-1:0]  ld_done_off,
  output logic              if_done_valid,
  output logic [BLK_W-1:0]  if_done_blk
);

  localparam int DIDX_W = $clog2(DATA_N);
  localparam int IIDX_W = $clog2(INST_N);

  function automatic logic names_data(input logic [GIDX_W-1:0] g);
    return int'(g) < DATA_N;
  endfunction

  function automatic logic names_inst(input logic [GIDX_W-1:0] g);
    return (int'(g) >= DATA_N) && (int'(g) < TOT_N);
  endfunction

  function automatic logic [IIDX_W-1:0] inst_slot(input logic [GIDX_W-1:0] g);
    return IIDX_W'(int'(g) - DATA_N);
  endfunction

  logic                           d_fill_valid, i_fill_valid;
  logic                           d_alloc, i_alloc;
  logic [DIDX_W-1:0]              d_alloc_idx;
  logic [IIDX_W-1:0]              i_alloc_idx;
  logic [DATA_N-1:0][BLK_W-1:0]   d_blk_tab;
  logic [INST_N-1:0][BLK_W-1:0]   i_blk_tab;
  logic [GIDX_W-1:0]              push_idx_d, push_idx_i;

  assign d_fill_valid = fill_valid && names_data(fill_idx);
  assign i_fill_valid = fill_valid && names_inst(fill_idx);

  mt_data_pool #(
    .ENTRIES(DATA_N), .SLOTS(MERGE_N), .BLK_W(BLK_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .ld_valid   (ld_miss_valid),
    .ld_blk     (ld_miss_addr[ADDR_W-1:OFF_W]),
    .ld_off     (ld_miss_addr[OFF_W-1:0]),
    .ld_dst     (ld_miss_dst),
    .fill_valid (d_fill_valid),
    .fill_idx   (DIDX_W'(fill_idx)),
    .alloc_fire (d_alloc),
    .alloc_idx  (d_alloc_idx),
    .replay     (ld_replay),
    .blk_tab    (d_blk_tab),
    .done_valid (ld_done_valid),
    .done_dst   (ld_done_dst),
    .done_off   (ld_done_off)
  );

  mt_inst_pool #(
    .ENTRIES(INST_N), .BLK_W(BLK_W)
  ) u_inst (
    .clk        (clk),
    .rst_n      (rst_n),
    .if_valid   (if_miss_valid),
    .if_blk     (if_miss_addr[ADDR_W-1:OFF_W]),
    .fill_valid (i_fill_valid),
    .fill_idx   (inst_slot(fill_idx)),
    .alloc_fire (i_alloc),
    .alloc_idx  (i_alloc_idx),
    .stall      (if_stall),
    .blk_tab    (i_blk_tab),
    .done_valid (if_done_valid),
    .done_blk   (if_done_blk)
  );

  assign push_idx_d = GIDX_W'(d_alloc_idx);
  assign push_idx_i = GIDX_W'(int'(i_alloc_idx) + DATA_N);

  mt_req_queue #(
    .DEPTH(TOT_N), .IDX_W(GIDX_W)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_a     (d_alloc),
    .idx_a      (push_idx_d),
    .push_b     (i_alloc),
    .idx_b      (push_idx_i),
    .head_valid (req_valid),
    .head_idx   (req_idx)
  );

  assign req_blk = names_data(req_idx) ? d_blk_tab[DIDX_W'(req_idx)]
                                       : i_blk_tab[inst_slot(req_idx)];

  AST_STALL_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    if_stall |-> if_miss_valid); // R9

  AST_REQ_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_idx) < TOT_N)); // R6

  AST_NO_FILL_NO_IDONE: assert property (@(posedge clk) disable iff (!rst_n)
    if_done_valid |-> i_fill_valid); // R10

endmodule

// File: tb/miss_tracker_test.sv
module miss_tracker_test;

  logic        clk, rst_n;
  logic        ld_miss_valid, if_miss_valid, fill_valid;
  logic [31:0] ld_miss_addr, if_miss_addr;
  logic [5:0]  ld_miss_dst;
  logic [3:0]  fill_idx;
  logic        ld_replay, if_stall, req_valid, ld_done_valid, if_done_valid;
  logic [3:0]  req_idx;
  logic [26:0] req_blk, if_done_blk;
  logic [5:0]  ld_done_dst;
  logic [4:0]  ld_done_off;

  miss_tracker uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  // reference state
  int mst[6], mblk[6], mcnt[6], mptr[6], mdst[6][4], moff[6][4];
  int ibusy[4], iblk[4], sent[10];
  int q[$];
  // per-cycle expectations
  int e_hit, e_free, e_ifree, e_drain, e_req_idx, e_req_blk, e_if_blk;
  bit e_merge, e_alloc, e_replay, e_stall, e_req, e_done, e_ifdone;
  int n_merge = 0, n_rep_full = 0, n_rep_slots = 0, n_done = 0, n_stall = 0, n_ign = 0, n_ifdone = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_eval();
    int blk, f;
    blk = int'(ld_miss_addr[31:5]);
    e_hit = -1; e_free = -1; e_ifree = -1; e_drain = -1;
    for (int j = 5; j >= 0; j--) begin
      if (mst[j] == 1 && mblk[j] == blk) e_hit = j;
      if (mst[j] == 0) e_free = j;
      if (mst[j] == 2) e_drain = j;
    end
    for (int j = 3; j >= 0; j--) if (ibusy[j] == 0) e_ifree = j;
    e_merge  = ld_miss_valid && e_hit >= 0 && mcnt[e_hit < 0 ? 0 : e_hit] < 4;
    e_alloc  = ld_miss_valid && e_hit < 0 && e_free >= 0;
    e_replay = ld_miss_valid && !e_merge && !e_alloc;
    e_stall  = if_miss_valid && e_ifree < 0;
    e_req    = q.size() > 0;
    e_req_idx = e_req ? q[0] : 0;
    e_req_blk = (e_req_idx < 6) ? mblk[e_req_idx] : iblk[e_req_idx - 6];
    e_done   = e_drain >= 0;
    f = int'(fill_idx);
    e_ifdone = fill_valid && f >= 6 && f < 10 && ibusy[(f >= 6 && f < 10) ? f - 6 : 0] == 1;
    e_if_blk = e_ifdone ? iblk[f - 6] : 0;
  endtask

  task automatic compare();
    chk("R4/R5 ld_replay", int'(ld_replay), int'(e_replay));
    chk("R9 if_stall", int'(if_stall), int'(e_stall));
    chk("R6 req_valid", int'(req_valid), int'(e_req));
    if (e_req && req_valid) begin
      chk("R2/R6 req_idx", int'(req_idx), e_req_idx);
      chk("R3/R6 req_blk", int'(req_blk), e_req_blk);
    end
    chk("R7 ld_done_valid", int'(ld_done_valid), int'(e_done));
    if (e_done && ld_done_valid) begin
      chk("R7 ld_done_dst", int'(ld_done_dst), mdst[e_drain][mptr[e_drain]]);
      chk("R7 ld_done_off", int'(ld_done_off), moff[e_drain][mptr[e_drain]]);
    end
    chk("R8/R10 if_done_valid", int'(if_done_valid), int'(e_ifdone));
    if (e_ifdone && if_done_valid) chk("R8 if_done_blk", int'(if_done_blk), e_if_blk);
  endtask

  task automatic model_step();
    int f;
    f = int'(fill_idx);
    if (e_req) begin
      void'(q.pop_front());
      sent[e_req_idx] = 1;
    end
    if (e_done) begin
      n_done++;
      if (mptr[e_drain] == mcnt[e_drain] - 1) begin
        mst[e_drain] = 0; mcnt[e_drain] = 0; mptr[e_drain] = 0;
      end else mptr[e_drain]++;
    end
    if (fill_valid) begin
      if (f < 6 && mst[f] == 1) begin mst[f] = 2; sent[f] = 0; end
      else if (e_ifdone) begin ibusy[f - 6] = 0; sent[f] = 0; n_ifdone++; end
      else n_ign++;
    end
    if (e_merge) begin
      mdst[e_hit][mcnt[e_hit]] = int'(ld_miss_dst);
      moff[e_hit][mcnt[e_hit]] = int'(ld_miss_addr[4:0]);
      mcnt[e_hit]++;
      n_merge++;
    end
    if (e_alloc) begin
      mst[e_free] = 1; mblk[e_free] = int'(ld_miss_addr[31:5]);
      mcnt[e_free] = 1; mptr[e_free] = 0;
      mdst[e_free][0] = int'(ld_miss_dst); moff[e_free][0] = int'(ld_miss_addr[4:0]);
      q.push_back(e_free);
    end
    if (e_replay) begin
      if (e_hit >= 0) n_rep_slots++; else n_rep_full++;
    end
    if (if_miss_valid && e_ifree >= 0) begin
      ibusy[e_ifree] = 1; iblk[e_ifree] = int'(if_miss_addr[31:5]);
      q.push_back(6 + e_ifree);
    end
    if (e_stall) n_stall++;
  endtask

  task automatic cycle(bit lv, int lblk, int loff, int ldst, bit iv, int iblk_a, bit fv, int fidx);
    @(negedge clk);
    ld_miss_valid = lv;
    ld_miss_addr  = {lblk[26:0], loff[4:0]};
    ld_miss_dst   = ldst[5:0];
    if_miss_valid = iv;
    if_miss_addr  = {iblk_a[26:0], 5'd0};
    fill_valid    = fv;
    fill_idx      = fidx[3:0];
    #1;
    model_eval();
    compare();
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cycle(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int j = 0; j < 6; j++) begin mst[j] = 0; mcnt[j] = 0; mptr[j] = 0; end
    for (int j = 0; j < 4; j++) ibusy[j] = 0;
    for (int j = 0; j < 10; j++) sent[j] = 0;
    rst_n = 1'b0;
    ld_miss_valid = 0; if_miss_valid = 0; fill_valid = 0;
    ld_miss_addr = '0; if_miss_addr = '0; ld_miss_dst = '0; fill_idx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: quiet after reset
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 ld_done_valid", int'(ld_done_valid), 0);
    chk("R1 if_done_valid", int'(if_done_valid), 0);
    chk("R1 ld_replay", int'(ld_replay), 0);
    chk("R1 if_stall", int'(if_stall), 0);

    // R3 merges, R5 full merge list
    cycle(1, 'h100, 0, 1, 0, 0, 0, 0);
    cycle(1, 'h100, 4, 2, 0, 0, 0, 0);
    cycle(1, 'h100, 8, 3, 0, 0, 0, 0);
    cycle(1, 'h100, 12, 4, 0, 0, 0, 0);
    cycle(1, 'h100, 16, 5, 0, 0, 0, 0);
    // R2 fill remaining data entries, R4 pool full
    for (int k = 1; k < 6; k++) cycle(1, 'h100 + k, k, 10 + k, 0, 0, 0, 0);
    cycle(1, 'h1ff, 3, 20, 0, 0, 0, 0);
    // R9 instruction pool, same-cycle ordering R6
    cycle(1, 'h1fe, 0, 21, 1, 'h200, 0, 0);
    for (int k = 1; k < 4; k++) cycle(0, 0, 0, 0, 1, 'h200 + k, 0, 0);
    cycle(0, 0, 0, 0, 1, 'h2ff, 0, 0);
    idle(12);
    // R7 data fill, R10 refill while draining, R8 instr fill
    cycle(0, 0, 0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 1, 7);
    cycle(0, 0, 0, 0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0, 0, 1, 7);
    cycle(0, 0, 0, 0, 0, 0, 1, 13);
    idle(4);
    cycle(1, 'h100, 9, 30, 1, 'h201, 1, 2);
    idle(6);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit lv, iv, fv;
      int fidx, cand[$];
      lv = ($urandom % 100) < 40;
      iv = ($urandom % 100) < 25;
      fv = 0; fidx = 0;
      for (int j = 0; j < 10; j++) if (sent[j] == 1) cand.push_back(j);
      if (cand.size() > 0 && ($urandom % 100) < 30) begin
        fv = 1; fidx = cand[$urandom % cand.size()];
      end else if (($urandom % 100) < 5) begin
        int t;
        t = int'($urandom % 16);
        if ((t < 6 && mst[t] != 1) || (t >= 6 && t < 10 && ibusy[t - 6] == 0) || t >= 10) begin
          fv = 1; fidx = t;
        end
      end
      cycle(lv, 'h300 + int'($urandom % 9), int'($urandom % 32), int'($urandom % 64),
            iv, 'h400 + int'($urandom % 16), fv, fidx);
    end
    idle(4);

    chk("R3 merges seen", int'(n_merge > 0), 1);
    chk("R4 pool-full replays seen", int'(n_rep_full > 0), 1);
    chk("R5 slot-full replays seen", int'(n_rep_slots > 0), 1);
    chk("R7 completions seen", int'(n_done > 0), 1);
    chk("R8 instruction fills seen", int'(n_ifdone > 0), 1);
    chk("R9 stalls seen", int'(n_stall > 0), 1);
    chk("R10 ignored fills seen", int'(n_ign > 0), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule